// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block decides whether an arriving Ethernet frame should be kept, judging only by its 48-bit destination address. The address enters one byte per cycle on a byte strobe, the first byte flagged by a start strobe. The frame length comes in on the same cycle as the start byte. One cycle after the sixth address byte is taken, the block raises a one-cycle decision pulse with an accept flag.

Software programs the filter through a small write port. Two full unicast addresses can be stored. A 64-bit group hash table acts as a single-hash Bloom filter. A four-bit enable word selects which paths may accept a frame. The enable word and the table are copied into a working set when a frame starts, so a register write never affects a frame whose address is already arriving.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `dec_valid` and `dec_accept` are low, and every register reads as zero, so every frame is rejected until software programs the filter.
- R2: When enable bit 0 is set, a frame whose destination equals unicast slot 0 is accepted. A slot is written as a low word (select 0) holding address bytes 0 to 3 in bits 7:0 up to 31:24, and a high word (select 1) holding byte 4 in bits 7:0 and byte 5 in bits 15:8. Byte 0 is the first byte on `rx_byte`.
- R3: When enable bit 1 is set, a frame whose destination equals unicast slot 1 is accepted. Slot 1 uses select 2 for the low word and select 3 for the high word, packed as in R2.
- R4: When enable bit 3 is set, a destination of all ones is accepted. The enable word is written with select 6 and takes bits 3:0 of the write data.
- R5: The hash index is the XOR of the eight 6-bit fields of the address. The address bit stream runs byte 0 first, each byte least significant bit first, and bit k of the stream lands in position k mod 6. Indices 0 to 31 pick that bit of the table low word (select 4). Indices 32 to 63 pick bit (index - 32) of the table high word (select 5). A set table bit accepts the frame, subject to R6.
- R6: With enable bit 2 clear, the hash path can accept only when bit 0 of address byte 0 (the group bit) is set. With enable bit 2 set, the hash path also accepts individual addresses.
- R7: A frame whose `rx_len` at the start byte is below 12 is rejected, whatever the address.
- R8: `dec_valid` is high for exactly one cycle, the cycle after the edge that takes the sixth address byte. `dec_accept` is never high while `dec_valid` is low.
- R9: A register write made after a frame's start byte has been taken affects the next frame only.
- R10: A start strobe in the middle of an address restarts collection, and the partial address gives no decision.
- R11: Cycles with `rx_valid` low between address bytes are skipped and do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0..6, see R2 to R5) |
| cfg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Address byte present this cycle |
| rx_start | input | 1 | This byte is address byte 0 |
| rx_byte | input | 8 | Address byte |
| rx_len | input | LEN_W | Frame length in bytes, taken with the start byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted, qualified by `dec_valid` |

## Verification
The decision is due exactly one cycle after the edge that takes the sixth byte. Inputs are driven on falling edges, and the bench reads `dec_valid` and `dec_accept` on the falling edge right after the last byte. It also confirms that `dec_valid` is low on the falling edge where the last byte is presented, and again one cycle after the pulse. Register writes take effect on the edge after the write strobe. For this reason the bench model copies its register image at the moment it presents a start byte, which matches the point where the block takes its working copy.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int HASH_W     = 6;
  localparam int TBL_W      = 1 << HASH_W;
  localparam int REG_W      = 32;
  localparam int HI_W       = ADDR_W - REG_W;
  localparam int FIELDS     = ADDR_W / HASH_W;

  typedef enum logic [2:0] {
    SEL_UC0_LO = 3'd0,
    SEL_UC0_HI = 3'd1,
    SEL_UC1_LO = 3'd2,
    SEL_UC1_HI = 3'd3,
    SEL_HT_LO  = 3'd4,
    SEL_HT_HI  = 3'd5,
    SEL_CTRL   = 3'd6
  } cfg_sel_e;

  typedef struct packed {
    logic [ADDR_W-1:0] uc0;
    logic [ADDR_W-1:0] uc1;
    logic [TBL_W-1:0]  htab;
    logic              en_bcast;
    logic              en_indiv;
    logic              en_uc1;
    logic              en_uc0;
  } cfg_t;

  function automatic logic [HASH_W-1:0] fold_hash(input logic [ADDR_W-1:0] a);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int f = 0; f < FIELDS; f++) h ^= a[f*HASH_W +: HASH_W];
    return h;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             snap,
  output cfg_t             cfg_q
);
  logic [REG_W-1:0] lo_q [2];
  logic [HI_W-1:0]  hi_q [2];
  logic [REG_W-1:0] ht_lo_q, ht_hi_q;
  logic [3:0]       ctrl_q;

  // Two unicast slots share one layout: low word at 2*g, high word at 2*g+1.
  for (genvar g = 0; g < 2; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (we) begin
        if (sel == 3'(2*g))     lo_q[g] <= wdata;
        if (sel == 3'(2*g + 1)) hi_q[g] <= wdata[HI_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ht_lo_q <= '0;
      ht_hi_q <= '0;
      ctrl_q  <= '0;
    end else if (we) begin
      if (sel == SEL_HT_LO) ht_lo_q <= wdata;
      if (sel == SEL_HT_HI) ht_hi_q <= wdata;
      if (sel == SEL_CTRL)  ctrl_q  <= wdata[3:0];
    end
  end

  // Working copy taken at frame start; a write on the same edge lands after it.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (snap) begin
      cfg_q.uc0      <= {hi_q[0], lo_q[0]};
      cfg_q.uc1      <= {hi_q[1], lo_q[1]};
      cfg_q.htab     <= {ht_hi_q, ht_lo_q};
      cfg_q.en_uc0   <= ctrl_q[0];
      cfg_q.en_uc1   <= ctrl_q[1];
      cfg_q.en_indiv <= ctrl_q[2];
      cfg_q.en_bcast <= ctrl_q[3];
    end
  end
endmodule

// File: rtl/rxf_addr_collect.sv
module rxf_addr_collect
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_start,
  input  logic [7:0]        rx_byte,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              addr_last,
  output logic [ADDR_W-1:0] addr_full,
  output logic              len_ok
);
  localparam int CNT_W  = $clog2(ADDR_BYTES);
  localparam int HOLD_W = ADDR_W - 8;

  logic [CNT_W-1:0]  cnt_q;
  logic              active_q;
  logic [HOLD_W-1:0] hold_q;

  assign addr_last = rx_valid && !rx_start && active_q &&
                     (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign addr_full = {rx_byte, hold_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      hold_q   <= '0;
      len_ok   <= 1'b0;
    end else if (rx_valid) begin
      if (rx_start) begin
        hold_q[7:0] <= rx_byte;
        cnt_q       <= CNT_W'(1);
        active_q    <= 1'b1;
        len_ok      <= (rx_len >= LEN_W'(MIN_LEN));
      end else if (active_q) begin
        if (addr_last) begin
          active_q <= 1'b0;
        end else begin
          hold_q[int'(cnt_q)*8 +: 8] <= rx_byte;
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_last,
  input  logic [ADDR_W-1:0] addr_full,
  input  logic              len_ok,
  input  cfg_t              cfg,
  output logic              dec_valid,
  output logic              dec_accept
);
  logic [HASH_W-1:0] idx;
  logic hit_uc0, hit_uc1, hit_bc, hit_hash, hit_any;

  always_comb begin
    idx      = fold_hash(addr_full);
    hit_uc0  = cfg.en_uc0 && (addr_full == cfg.uc0);
    hit_uc1  = cfg.en_uc1 && (addr_full == cfg.uc1);
    hit_bc   = cfg.en_bcast && (&addr_full);
    hit_hash = cfg.htab[idx] && (cfg.en_indiv || addr_full[0]);
    hit_any  = hit_uc0 || hit_uc1 || hit_bc || hit_hash;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid  <= addr_last;
      dec_accept <= addr_last && len_ok && hit_any;
    end
  end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [31:0]      cfg_wdata,
  input  logic             rx_valid,
  input  logic             rx_start,
  input  logic [7:0]       rx_byte,
  input  logic [LEN_W-1:0] rx_len,
  output logic             dec_valid,
  output logic             dec_accept
);
  cfg_t              cfg_q;
  logic              addr_last;
  logic [ADDR_W-1:0] addr_full;
  logic              len_ok;

  rxf_cfg_regs u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .snap  (rx_valid && rx_start),
    .cfg_q (cfg_q)
  );

  rxf_addr_collect #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_col (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_start  (rx_start),
    .rx_byte   (rx_byte),
    .rx_len    (rx_len),
    .addr_last (addr_last),
    .addr_full (addr_full),
    .len_ok    (len_ok)
  );

  rxf_decide u_dec (
    .clk        (clk),
    .rst        (rst),
    .addr_last  (addr_last),
    .addr_full  (addr_full),
    .len_ok     (len_ok),
    .cfg        (cfg_q),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept)
  );
endmodule

// File: rtl/rx_dest_filter_chk.sv
module rx_dest_filter_chk #(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             rx_start,
  input logic [LEN_W-1:0] rx_len,
  input logic             dec_valid,
  input logic             dec_accept,
  input logic             addr_last,
  input logic [47:0]      addr_full,
  input logic [3:0]       en_bits
);
  logic short_q;
  always_ff @(posedge clk) begin
    if (rst)                      short_q <= 1'b0;
    else if (rx_valid && rx_start) short_q <= (rx_len < LEN_W'(MIN_LEN));
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!dec_valid && !dec_accept));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) dec_valid |=> !dec_valid);

  // R8
  accept_qualified_chk: assert property (@(posedge clk) disable iff (rst) dec_accept |-> dec_valid);

  // R7
  short_reject_chk: assert property (@(posedge clk) disable iff (rst) (dec_valid && short_q) |-> !dec_accept);

  // R4
  bcast_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_last && en_bits[3] && (&addr_full) && !short_q) |=> dec_accept);

  // R6
  indiv_block_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_last && (en_bits == 4'b0000) && !addr_full[0]) |=> !dec_accept);
endmodule

bind rx_dest_filter rx_dest_filter_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rx_valid   (rx_valid),
  .rx_start   (rx_start),
  .rx_len     (rx_len),
  .dec_valid  (dec_valid),
  .dec_accept (dec_accept),
  .addr_last  (addr_last),
  .addr_full  (addr_full),
  .en_bits    ({cfg_q.en_bcast, cfg_q.en_indiv, cfg_q.en_uc1, cfg_q.en_uc0})
);

// File: tb/rx_dest_filter_tb.sv
`timescale 1ns/1ps
module rx_dest_filter_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        rx_valid, rx_start;
  logic [7:0]  rx_byte;
  logic [15:0] rx_len;
  logic        dec_valid, dec_accept;

  int n_chk  = 0;
  int n_fail = 0;

  logic [47:0] m_uc0, m_uc1;
  logic [63:0] m_ht;
  logic [3:0]  m_ctrl;

  always #10 clk = ~clk;

  rx_dest_filter u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_start(rx_start), .rx_byte(rx_byte), .rx_len(rx_len),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  function automatic logic [5:0] bhash(input logic [47:0] a);
    logic [5:0] h = '0;
    for (int f = 0; f < 8; f++) h ^= a[6*f +: 6];
    return h;
  endfunction

  function automatic logic expect_acc(input logic [47:0] a, input logic [15:0] len);
    logic hit;
    hit = (m_ctrl[0] && a == m_uc0) || (m_ctrl[1] && a == m_uc1) ||
          (m_ctrl[3] && &a) || (m_ht[bhash(a)] && (m_ctrl[2] || a[0]));
    return hit && (len >= 16'd12);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Write one register; the model follows on the same edge.
  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    case (s)
      3'd0: m_uc0[31:0]  = d;
      3'd1: m_uc0[47:32] = d[15:0];
      3'd2: m_uc1[31:0]  = d;
      3'd3: m_uc1[47:32] = d[15:0];
      3'd4: m_ht[31:0]   = d;
      3'd5: m_ht[63:32]  = d;
      3'd6: m_ctrl       = d[3:0];
      default: ;
    endcase
  endtask

  task automatic set_uc(input int slot, input logic [47:0] a);
    wr(3'(2*slot), a[31:0]);
    wr(3'(2*slot + 1), {16'h0, a[47:32]});
  endtask

  task automatic send(input string req, input logic [47:0] a, input logic [15:0] len,
                      input logic gaps);
    logic exp;
    exp = expect_acc(a, len);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 5) check("R8 quiet before last byte", dec_valid, 1'b0);
      rx_valid = 1'b1; rx_start = (i == 0); rx_byte = a[8*i +: 8]; rx_len = len;
      if (gaps && i < 5) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_start = 1'b0;
      end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_start = 1'b0;
    check({req, " valid"}, dec_valid, 1'b1);
    check(req, dec_accept, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'd20240611));
    m_uc0 = '0; m_uc1 = '0; m_ht = '0; m_ctrl = '0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    rx_valid = 0; rx_start = 0; rx_byte = 0; rx_len = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset valid", dec_valid, 1'b0);
    check("R1 reset accept", dec_accept, 1'b0);
    send("R1 broadcast unprogrammed", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0);
    send("R1 group unprogrammed", 48'h0000_0000_0001, 16'd64, 1'b0);

    // R2 exact slot 0
    set_uc(0, 48'h6655_4433_2211);
    wr(3'd6, 32'h1);
    send("R2 slot0 hit", 48'h6655_4433_2211, 16'd64, 1'b0);
    send("R2 slot0 byte5 differs", 48'h6755_4433_2211, 16'd64, 1'b0);
    wr(3'd6, 32'h0);
    send("R2 slot0 disabled", 48'h6655_4433_2211, 16'd64, 1'b0);

    // R3 exact slot 1
    set_uc(1, 48'hA0B0_C0D0_E0F2);
    wr(3'd6, 32'h2);
    send("R3 slot1 hit", 48'hA0B0_C0D0_E0F2, 16'd64, 1'b0);
    send("R3 slot0 not enabled", 48'h6655_4433_2211, 16'd64, 1'b0);

    // R4 broadcast
    wr(3'd6, 32'h8);
    send("R4 broadcast on", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0);
    wr(3'd6, 32'h0);
    send("R4 broadcast off", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0);

    // R5 hash, both table halves; R6 individual gating
    wr(3'd4, 32'h0000_0002);
    send("R5 group idx1 low word", 48'h0000_0000_0001, 16'd64, 1'b0);
    wr(3'd4, 32'h0);
    wr(3'd5, 32'h4000_0000);
    send("R5 group idx62 high word", 48'hFC00_0000_0001, 16'd64, 1'b0);
    wr(3'd5, 32'h0);
    wr(3'd4, 32'h0000_0004);
    send("R6 individual blocked", 48'h0000_0000_0002, 16'd64, 1'b0);
    wr(3'd6, 32'h4);
    send("R6 individual allowed", 48'h0000_0000_0002, 16'd64, 1'b0);
    wr(3'd4, 32'h0);

    // R7 length threshold
    wr(3'd6, 32'h8);
    send("R7 len 11", 48'hFFFF_FFFF_FFFF, 16'd11, 1'b0);
    send("R7 len 12", 48'hFFFF_FFFF_FFFF, 16'd12, 1'b0);

    // R8 pulse lasts one cycle
    @(negedge clk);
    check("R8 pulse one cycle", dec_valid, 1'b0);

    // R11 idle gaps between bytes
    send("R11 gaps broadcast", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b1);

    // R9 mid-frame write affects the next frame only
    set_uc(0, 48'h1234_5678_9ABC);
    wr(3'd6, 32'h1);
    a = 48'h1234_5678_9ABC;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_start = (i == 0); rx_byte = a[8*i +: 8]; rx_len = 16'd64;
      cfg_we = (i == 2); cfg_sel = 3'd0; cfg_wdata = 32'h0;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_start = 1'b0; cfg_we = 1'b0;
    m_uc0[31:0] = 32'h0;
    check("R9 in-flight keeps old slot", dec_accept, 1'b1);
    send("R9 next frame sees new slot", a, 16'd64, 1'b0);

    // R10 restart mid-address
    wr(3'd6, 32'h8);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_start = (i == 0); rx_byte = 8'hFF; rx_len = 16'd64;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_start = 1'b0;
    check("R10 no decision on partial", dec_valid, 1'b0);
    send("R10 restarted frame", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_start = (i == 0); rx_byte = 8'h00; rx_len = 16'd64;
    end
    send("R10 restart over partial", 48'hFFFF_FFFF_FFFF, 16'd64, 1'b0);

    // Random mix over all paths (R2 R3 R4 R5 R6 R7 R11)
    for (int n = 0; n < 400; n++) begin
      logic [15:0] len;
      if (n % 25 == 0) begin
        set_uc(0, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
        set_uc(1, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
        wr(3'd4, $urandom & $urandom);
        wr(3'd5, $urandom & $urandom);
        wr(3'd6, $urandom);
      end
      case ($urandom % 5)
        0: a = m_uc0;
        1: a = m_uc1;
        2: a = 48'hFFFF_FFFF_FFFF;
        3: a = {$urandom, $urandom};
        default: a = {$urandom, $urandom} | 48'h1;
      endcase
      len = ($urandom % 10 == 0) ? 16'($urandom % 12) : 16'(12 + $urandom % 1500);
      send("R5 random mix", a, len, 1'($urandom));
    end

    summary();
    $finish;
  end
endmodule